// File: doc/BRIEF.md
# Next Program Counter Unit

This block keeps the program counter of a single-cycle 32-bit integer core and works out, every clock, the address of the next instruction to fetch. The decoder hands it one flag per conditional branch kind and one flag for each of the two jump kinds. The register file hands it both source operand values, and the immediate logic hands it the decoded immediate. The block compares the two operands for the six branch conditions in the same cycle. It then picks the next address under a fixed priority and loads it into the PC register on the next rising clock edge.

Alongside the PC the block drives the combinational next address, a flag that tells whether the current conditional branch is taken, and the return address that the write-back stage stores for both jump kinds. Fetch, decode, immediate extraction and register write-back sit outside the block.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc_q` becomes 0 after that edge, whatever the branch and jump flags say.
- R2: With no branch or jump flag raised, `pc_nxt` equals `pc_q + 4`.
- R3: When a conditional branch is taken, `pc_nxt` equals `pc_q + imm_val`.
- R4: With `jmp_link` raised and no taken branch, `pc_nxt` equals `pc_q + imm_val`.
- R5: With `jmp_reg` raised, no taken branch and `jmp_link` low, `pc_nxt` equals `src_a + imm_val` with bit 0 cleared.
- R6: The next-address choice follows a fixed priority: taken branch, then `jmp_link`, then `jmp_reg`, then the sequential address. A branch that is not taken does not block a jump.
- R7: `br_eq` is taken when `src_a == src_b`, and `br_ne` is taken when they differ.
- R8: `br_lt` is taken when `src_a < src_b` as two's-complement numbers, and `br_ge` is taken otherwise.
- R9: `br_ltu` is taken when `src_a < src_b` as unsigned numbers, and `br_geu` is taken otherwise.
- R10: `br_take` is high only while a branch flag is raised and its condition holds. A jump or a plain instruction never raises it.
- R11: `link_pc` equals `pc_q + 4` in every cycle.
- R12: When `rst_n` is high at a rising edge, `pc_q` takes the value that `pc_nxt` had before that edge.
- R13: All address sums wrap modulo 2^32. From PC `0xFFFFFFFC` the sequential address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| br_eq | input | 1 | Current instruction is branch-if-equal |
| br_ne | input | 1 | Current instruction is branch-if-not-equal |
| br_lt | input | 1 | Current instruction is signed branch-if-less |
| br_ge | input | 1 | Current instruction is signed branch-if-greater-or-equal |
| br_ltu | input | 1 | Current instruction is unsigned branch-if-less |
| br_geu | input | 1 | Current instruction is unsigned branch-if-greater-or-equal |
| jmp_link | input | 1 | Current instruction is a PC-relative jump |
| jmp_reg | input | 1 | Current instruction is a register-indirect jump |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| imm_val | input | 32 | Decoded sign-extended immediate |
| pc_q | output | 32 | Current program counter |
| pc_nxt | output | 32 | Next fetch address, combinational |
| br_take | output | 1 | Conditional branch taken this cycle |
| link_pc | output | 32 | Return address for the jump write-back |

## Verification
The comparisons use operand pairs with opposite sign bits, such as -1 against 1. In those cases the signed and unsigned compares must disagree, so a unit that mixes them up is caught. Equal and unequal pairs separate the equality tests. Some patterns raise several flags together: a taken branch with a register jump, a PC-relative jump with a register jump, and an untaken branch with a register jump. Each of these yields a different address depending on which source wins. An odd register-jump target shows whether bit 0 is cleared. A jump to the top of the address space followed by a plain step shows the wrap to zero. A reset applied while a jump flag is high shows that reset wins.

// File: rtl/npc_pkg.sv
// Package npc_pkg
// Shared types for the next program counter unit: the source that the
// next address is taken from, and the bundle of branch kind flags.
// Assumes the decoder raises at most one branch kind flag at a time.
package npc_pkg;

    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_PCREL  = 2'd2,
        SRC_REGIND = 2'd3
    } npc_src_e;

    typedef struct packed {
        logic eq;
        logic ne;
        logic lt;
        logic ge;
        logic ltu;
        logic geu;
    } br_kind_t;

endpackage

// File: rtl/npc_branch_cmp.sv
// Module npc_branch_cmp
// Resolves the conditional branch of the current instruction in the same
// cycle. CMP_STYLE 0 uses separate comparators, and CMP_STYLE 1 derives
// every condition from one shared subtraction. Assumes at most one kind
// flag is set. The output is low when no kind flag is set.
module npc_branch_cmp
    import npc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int CMP_STYLE = 1
) (
    input  br_kind_t          kind,
    input  logic [XLEN-1:0]   op_a,
    input  logic [XLEN-1:0]   op_b,
    output logic              taken
);

    localparam int MSB = XLEN - 1;

    logic same;
    logic less_s;
    logic less_u;

    generate
        if (CMP_STYLE == 0) begin : g_direct
            // Separate comparators for equality, signed and unsigned order.
            always_comb begin
                same   = (op_a == op_b);
                less_s = ($signed(op_a) < $signed(op_b));
                less_u = (op_a < op_b);
            end
        end else begin : g_shared
            logic [XLEN:0] diff;
            // One subtraction a - b. The carry out means a >= b unsigned.
            always_comb begin
                diff   = {1'b0, op_a} + {1'b0, ~op_b} + {{XLEN{1'b0}}, 1'b1};
                same   = (diff[MSB:0] == '0);
                less_u = ~diff[XLEN];
                less_s = (op_a[MSB] ^ op_b[MSB]) ? op_a[MSB] : less_u;
            end
        end
    endgenerate

    // Combine each kind flag with its condition.
    always_comb begin
        taken = (kind.eq  &  same)
              | (kind.ne  & ~same)
              | (kind.lt  &  less_s)
              | (kind.ge  & ~less_s)
              | (kind.ltu &  less_u)
              | (kind.geu & ~less_u);
    end

endmodule

// File: rtl/npc_target_sel.sv
// Module npc_target_sel
// Builds the candidate fetch addresses (sequential, PC-relative and
// register-indirect) and picks one under the fixed priority: taken
// branch, PC-relative jump, register jump, sequential. It also returns
// the link address. All sums wrap at XLEN bits.
module npc_target_sel
    import npc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc_cur,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] imm,
    input  logic            br_hit,
    input  logic            pcrel_jmp,
    input  logic            reg_jmp,
    output logic [XLEN-1:0] pc_next,
    output logic [XLEN-1:0] link
);

    localparam logic [XLEN-1:0] STEP    = XLEN'(INSN_BYTES);
    localparam logic [XLEN-1:0] LSB_CLR = ~{{(XLEN-1){1'b0}}, 1'b1};

    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] rel_addr;
    logic [XLEN-1:0] ind_addr;
    npc_src_e        src;

    // Candidate addresses. Bit 0 of the register target is dropped.
    always_comb begin
        seq_addr = pc_cur + STEP;
        rel_addr = pc_cur + imm;
        ind_addr = (op_a + imm) & LSB_CLR;
    end

    // Fixed-priority choice of the address source.
    always_comb begin
        if (br_hit)         src = SRC_BRANCH;
        else if (pcrel_jmp) src = SRC_PCREL;
        else if (reg_jmp)   src = SRC_REGIND;
        else                src = SRC_SEQ;
    end

    // Route the chosen candidate to the output.
    always_comb begin
        case (src)
            SRC_BRANCH: pc_next = rel_addr;
            SRC_PCREL:  pc_next = rel_addr;
            SRC_REGIND: pc_next = ind_addr;
            default:    pc_next = seq_addr;
        endcase
    end

    // The return address is always the sequential address.
    always_comb begin
        link = seq_addr;
    end

endmodule

// File: rtl/npc_pc_reg.sv
// Module npc_pc_reg
// The program counter register. It loads RESET_PC when the synchronous
// active-low reset is low at a rising edge, and otherwise loads the next
// address. Reset takes precedence over everything else.
module npc_pc_reg #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] d,
    output logic [XLEN-1:0] q
);

    // Register the next address, or the reset address under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_PC;
        else        q <= d;
    end

endmodule

// File: rtl/npc_unit.sv
// Module npc_unit
// Next program counter unit of a single-cycle integer core. It holds the
// PC, resolves the current conditional branch, selects the next fetch
// address and supplies the jump return address. Assumes decoded flags,
// operands and immediate are stable well before the clock edge.
module npc_unit
    import npc_pkg::*;
#(
    parameter int               XLEN       = 32,
    parameter int               INSN_BYTES = 4,
    parameter logic [XLEN-1:0]  RESET_PC   = '0,
    parameter int               CMP_STYLE  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br_eq,
    input  logic            br_ne,
    input  logic            br_lt,
    input  logic            br_ge,
    input  logic            br_ltu,
    input  logic            br_geu,
    input  logic            jmp_link,
    input  logic            jmp_reg,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [XLEN-1:0] imm_val,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] pc_nxt,
    output logic            br_take,
    output logic [XLEN-1:0] link_pc
);

    br_kind_t kind;

    // Bundle the branch kind flags.
    always_comb begin
        kind = '{eq: br_eq, ne: br_ne, lt: br_lt, ge: br_ge,
                 ltu: br_ltu, geu: br_geu};
    end

    npc_branch_cmp #(
        .XLEN      (XLEN),
        .CMP_STYLE (CMP_STYLE)
    ) u_cmp (
        .kind  (kind),
        .op_a  (src_a),
        .op_b  (src_b),
        .taken (br_take)
    );

    npc_target_sel #(
        .XLEN       (XLEN),
        .INSN_BYTES (INSN_BYTES)
    ) u_sel (
        .pc_cur    (pc_q),
        .op_a      (src_a),
        .imm       (imm_val),
        .br_hit    (br_take),
        .pcrel_jmp (jmp_link),
        .reg_jmp   (jmp_reg),
        .pc_next   (pc_nxt),
        .link      (link_pc)
    );

    npc_pc_reg #(
        .XLEN     (XLEN),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pc_nxt),
        .q     (pc_q)
    );

endmodule

// File: rtl/npc_unit_chk.sv
// Module npc_unit_chk
// Property checker for npc_unit, attached through bind. It observes the
// top-level ports only.
module npc_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            br_eq,
    input logic            br_ne,
    input logic            br_lt,
    input logic            br_ge,
    input logic            br_ltu,
    input logic            br_geu,
    input logic            jmp_link,
    input logic            jmp_reg,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b,
    input logic [XLEN-1:0] imm_val,
    input logic [XLEN-1:0] pc_q,
    input logic [XLEN-1:0] pc_nxt,
    input logic            br_take,
    input logic [XLEN-1:0] link_pc
);

    logic any_br;
    assign any_br = br_eq | br_ne | br_lt | br_ge | br_ltu | br_geu;

    // R1
    reset_pc_zero_chk: assert property (@(posedge clk)
        !rst_n |=> pc_q == '0);

    // R12
    pc_follows_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pc_q == $past(pc_nxt));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_br && !jmp_link && !jmp_reg) |-> pc_nxt == pc_q + 32'd4);

    // R3
    taken_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_take |-> pc_nxt == pc_q + imm_val);

    // R5
    regjmp_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_reg && !jmp_link && !br_take) |-> pc_nxt[0] == 1'b0);

    // R10
    taken_needs_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_take |-> any_br);

    // R7
    eq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_eq && src_a == src_b) |-> br_take);

    // R11
    link_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_link || jmp_reg) |-> link_pc == pc_q + 32'd4);

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_eq    (br_eq),
    .br_ne    (br_ne),
    .br_lt    (br_lt),
    .br_ge    (br_ge),
    .br_ltu   (br_ltu),
    .br_geu   (br_geu),
    .jmp_link (jmp_link),
    .jmp_reg  (jmp_reg),
    .src_a    (src_a),
    .src_b    (src_b),
    .imm_val  (imm_val),
    .pc_q     (pc_q),
    .pc_nxt   (pc_nxt),
    .br_take  (br_take),
    .link_pc  (link_pc)
);

// File: tb/npc_unit_tb.sv
// Scoreboard bench for npc_unit: the driver pushes expected results
// computed from the requirements, and the monitor pops and compares them.
module npc_unit_tb;

    localparam int F_EQ   = 1;
    localparam int F_NE   = 2;
    localparam int F_LT   = 4;
    localparam int F_GE   = 8;
    localparam int F_LTU  = 16;
    localparam int F_GEU  = 32;
    localparam int F_JAL  = 64;
    localparam int F_JALR = 128;

    typedef struct {
        bit          comb_ok;
        logic [31:0] nxt;
        logic        take;
        logic [31:0] link;
        logic [31:0] pc_after;
        string       tag;
    } item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        br_eq = 0, br_ne = 0, br_lt = 0, br_ge = 0;
    logic        br_ltu = 0, br_geu = 0, jmp_link = 0, jmp_reg = 0;
    logic [31:0] src_a = 0, src_b = 0, imm_val = 0;
    logic [31:0] pc_q, pc_nxt, link_pc;
    logic        br_take;

    item_t       sb[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] pc_m = 'x;
    bit          pc_known = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    npc_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .br_eq(br_eq), .br_ne(br_ne), .br_lt(br_lt), .br_ge(br_ge),
        .br_ltu(br_ltu), .br_geu(br_geu),
        .jmp_link(jmp_link), .jmp_reg(jmp_reg),
        .src_a(src_a), .src_b(src_b), .imm_val(imm_val),
        .pc_q(pc_q), .pc_nxt(pc_nxt), .br_take(br_take), .link_pc(link_pc)
    );

    task automatic check32(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected results.
    task automatic drive(input bit rst, input int fl, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] imm,
                         input string tag);
        item_t it;
        logic  t;
        @(negedge clk);
        rst_n = ~rst;
        br_eq = fl[0]; br_ne = fl[1]; br_lt = fl[2]; br_ge = fl[3];
        br_ltu = fl[4]; br_geu = fl[5]; jmp_link = fl[6]; jmp_reg = fl[7];
        src_a = a; src_b = b; imm_val = imm;
        t = (fl[0] && a == b) || (fl[1] && a != b) ||
            (fl[2] && $signed(a) <  $signed(b)) ||
            (fl[3] && $signed(a) >= $signed(b)) ||
            (fl[4] && a < b) || (fl[5] && a >= b);
        it.comb_ok = pc_known;
        it.take    = t;
        it.link    = pc_m + 32'd4;
        if (t)          it.nxt = pc_m + imm;
        else if (fl[6]) it.nxt = pc_m + imm;
        else if (fl[7]) it.nxt = (a + imm) & 32'hFFFF_FFFE;
        else            it.nxt = pc_m + 32'd4;
        it.pc_after = rst ? 32'd0 : it.nxt;
        it.tag      = tag;
        pc_m        = it.pc_after;
        pc_known    = 1;
        sb.push_back(it);
    endtask

    // Monitor: compare combinational outputs mid-cycle and PC after the edge.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #3;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                if (it.comb_ok) begin
                    check32(it.tag, "pc_nxt", pc_nxt, it.nxt);
                    check32(it.tag, "br_take", {31'd0, br_take}, {31'd0, it.take});
                    check32({it.tag, " R11"}, "link_pc", link_pc, it.link);
                end
                @(posedge clk);
                #1;
                check32({it.tag, " R12"}, "pc_q", pc_q, it.pc_after);
            end
        end
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        drive(1, 0, 0, 0, 0, "R1 reset");
        drive(1, 0, 0, 0, 0, "R1 reset hold");
        drive(0, 0, 0, 0, 32'h40, "R2 seq");
        drive(0, 0, 5, 9, 32'h40, "R2 seq2");
        drive(0, F_EQ, 7, 7, 32'h20, "R7 R3 beq equal");
        drive(0, F_EQ, 7, 8, 32'h20, "R7 beq unequal");
        drive(0, F_NE, 7, 8, 32'hFFFF_FFF0, "R7 R3 bne differ");
        drive(0, F_NE, 3, 3, 32'h10, "R7 bne same");
        drive(0, F_LT, 32'hFFFF_FFFF, 1, 32'h8, "R8 blt neg<pos");
        drive(0, F_LTU, 32'hFFFF_FFFF, 1, 32'h8, "R9 bltu big<1");
        drive(0, F_GE, 32'hFFFF_FFFF, 1, 32'h8, "R8 bge neg>=pos");
        drive(0, F_GE, 4, 4, 32'h8, "R8 bge equal");
        drive(0, F_GEU, 32'hFFFF_FFFF, 1, 32'hC, "R9 bgeu big>=1");
        drive(0, F_LTU, 2, 3, 32'h4, "R9 bltu small");
        drive(0, F_JAL, 0, 0, 32'hFFFF_FFE0, "R4 R10 jal back");
        drive(0, F_JALR, 32'h1001, 0, 32'h20, "R5 R10 jalr odd");
        drive(0, F_EQ | F_JALR, 9, 9, 32'h30, "R6 branch over jalr");
        drive(0, F_JAL | F_JALR, 32'h500, 0, 32'h14, "R6 jal over jalr");
        drive(0, F_NE | F_JALR, 9, 9, 32'h3, "R6 untaken branch jalr");
        drive(0, F_JALR, 32'hFFFF_FFF8, 0, 32'h4, "R13 R5 to top");
        drive(0, 0, 0, 0, 0, "R13 wrap seq");
        drive(1, F_JAL, 0, 0, 32'h100, "R1 reset over jal");
        drive(0, F_GEU, 0, 0, 32'h40, "R9 bgeu zero");
        drive(0, 0, 0, 0, 0, "R2 idle");
        repeat (4) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule